// File: doc/BRIEF.md
# Four-Slot Pad Port Multiplexer

The block lets one host pad port reach four downstream slots, each holding a controller endpoint and a memory-card endpoint. Every host byte is one single-cycle exchange: the host presents a byte, and in the same cycle the block routes it to a downstream endpoint (also single-cycle, combinational), then returns one response byte and an acknowledge flag. The first byte of a sequence picks the slot and the kind of endpoint. After that the block either passes bytes straight through to that endpoint, or, in gather mode, walks all four controllers in turn.

In gather mode each slot owns a fixed frame of eight response bytes. The byte returned for frame position k is the one captured at position k during the previous frame. The current host byte refills that position from the current slot. A slot that stops acknowledging has the rest of its frame padded with 0xFF. Gather mode is armed by bit 0 of the request byte of an earlier sequence, so it takes effect only on the sequence that follows. A sequence-end input, meaning chip-select is released, returns the block to idle and keeps the armed flag.

Top module: `mt_route`

## Requirements
- R1: After reset, with no host byte presented, the response is 0xFF with no acknowledge and no endpoint is requested. Every entry of the eight-byte gather buffer starts at 0xFF, so the first gather frame ever returned is all 0xFF.
- R2: In idle, a first byte outside 0x01..0x04 and 0x81..0x84 returns 0xFF without acknowledge and the block stays idle.
- R3: In idle, byte 0x01..0x04 forwards 0x01 to controller slot (byte-1), and byte 0x81..0x84 forwards 0x81 to memory-card slot (byte&0x0F)-1. The endpoint's response and acknowledge are returned. The block leaves idle only if that endpoint acknowledges; an absent endpoint answers 0xFF with no acknowledge.
- R4: In memory-card mode each host byte passes unchanged to the selected card and the card's answer is returned. The first byte the card does not acknowledge returns the block to idle.
- R5: Without gather mode, the command byte passes to the selected controller and the request byte is sent to it as 0x00. Later bytes pass through until the controller does not acknowledge, and the block then returns to idle.
- R6: Bit 0 of the request byte (the third byte of a controller sequence) sets or clears the gather flag for the next sequence only. The flag survives a sequence end.
- R7: If gather is armed when a controller is selected, the 0x01 access byte is requested on all four controller slots at once. Otherwise only the selected slot is requested.
- R8: In gather mode the command byte is answered with 0x80 and acknowledged. The request byte is answered with 0x5A and acknowledged only if the command was 0x42.
- R9: After the request byte in gather mode, slots 0..3 each take eight bytes in order. Byte k of a frame returns the buffer entry k last written, and the host byte is forwarded to the current slot, whose answer is written into entry k.
- R10: Once the current slot fails to acknowledge within its frame, it is no longer requested and the remaining entries of that frame are written with 0xFF.
- R11: The 32nd gather byte (slot 3, position 7) is not acknowledged, and the block is idle afterwards.
- R12: A sequence end returns the block to idle from any state and clears the slot and position counters.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_valid | input | 1 | A host byte is exchanged this cycle |
| host_in | input | 8 | Byte from the host |
| seq_end | input | 1 | Chip-select released, sequence over |
| host_out | output | 8 | Response byte to the host |
| host_ack | output | 1 | Acknowledge to the host |
| pad_req | output | 4 | Per-slot controller request |
| pad_out | output | 8 | Byte sent to the requested controllers |
| pad_in | input | 32 | Controller answers, slot s in bits 8s+7..8s |
| pad_ack | input | 4 | Controller acknowledges |
| card_req | output | 4 | Per-slot memory-card request |
| card_out | output | 8 | Byte sent to the requested card |
| card_in | input | 32 | Card answers, slot s in bits 8s+7..8s |
| card_ack | input | 4 | Card acknowledges |

## Verification
The assertions assume that seq_end and host_valid are never raised in the same cycle. They also assume that endpoints answer combinationally within the cycle of their request, so a response is valid whenever host_valid is high. The bench drives a byte or a sequence end on separate falling edges and never both at once. Its endpoint models are combinational functions of a per-slot byte counter that restarts at each sequence end, so each answer and acknowledge is known in advance.

// File: rtl/mt_pkg.sv
// Shared types and protocol constants for the pad port multiplexer.
// Assumes byte-wide host and endpoint traffic.
package mt_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MCARD,
        ST_CMD,
        ST_REQ,
        ST_SINGLE,
        ST_GATHER
    } mt_state_e;

    localparam logic [7:0] PAD_ACCESS  = 8'h01;
    localparam logic [7:0] CARD_ACCESS = 8'h81;
    localparam logic [7:0] TAP_ID      = 8'h80;
    localparam logic [7:0] TAP_STATUS  = 8'h5A;
    localparam logic [7:0] GATHER_CMD  = 8'h42;
    localparam logic [7:0] IDLE_BYTE   = 8'hFF;
endpackage

// File: rtl/mt_first_decode.sv
// Decodes the first byte of a sequence into a controller or card slot.
// Controller codes are 1..NSLOT, card codes are 0x80 plus 1..NSLOT.
// Purely combinational; assumes NSLOT is below 128.
module mt_first_decode #(
    parameter int NSLOT = 4,
    parameter int SW    = $clog2(NSLOT)
) (
    input  logic [7:0]    byte_in,
    output logic          is_pad,
    output logic          is_card,
    output logic [SW-1:0] slot
);
    logic [6:0] low;
    logic       in_range;

    // Range test on the seven low bits shared by both code families
    always_comb begin
        low      = byte_in[6:0];
        in_range = (low >= 7'd1) && (low <= 7'(NSLOT));
        is_pad   = !byte_in[7] && in_range;
        is_card  = byte_in[7] && in_range;
        slot     = SW'(low - 7'd1);
    end
endmodule

// File: rtl/mt_slot_mux.sv
// Picks one slot's answer byte and acknowledge out of a flat bus.
// Assumes slot s occupies bits 8s+7..8s of the answer bus.
module mt_slot_mux #(
    parameter int NSLOT = 4,
    parameter int SW    = $clog2(NSLOT)
) (
    input  logic [NSLOT*8-1:0] rx_bus,
    input  logic [NSLOT-1:0]   ack_bus,
    input  logic [SW-1:0]      sel,
    output logic [7:0]         rx,
    output logic               ack
);
    // Indexed part-select of the chosen slot
    always_comb begin
        rx  = rx_bus[sel*8 +: 8];
        ack = ack_bus[sel];
    end
endmodule

// File: rtl/mt_gather_buf.sv
// Frame buffer for gather mode: FRAME byte entries, one write port,
// one combinational read port. All entries reset to 0xFF.
module mt_gather_buf #(
    parameter int FRAME = 8,
    parameter int FW    = $clog2(FRAME)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [FW-1:0] idx,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);
    logic [7:0] mem [FRAME];

    // Reset fill and single-entry refill
    always_ff @(posedge clk) begin
        for (int i = 0; i < FRAME; i++) begin
            if (!rst_n)
                mem[i] <= 8'hFF;
            else if (we && (idx == FW'(i)))
                mem[i] <= wdata;
        end
    end

    // Read of the entry at the current position
    always_comb rdata = mem[idx];
endmodule

// File: rtl/mt_route.sv
// Pad port multiplexer: routes host bytes to one of NSLOT controller or
// memory-card endpoints, or gathers all controllers in fixed frames.
// Assumes single-cycle combinational endpoints and that seq_end is never
// raised together with host_valid.
module mt_route #(
    parameter int NSLOT = 4,
    parameter int FRAME = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_valid,
    input  logic [7:0]         host_in,
    input  logic               seq_end,
    output logic [7:0]         host_out,
    output logic               host_ack,
    output logic [NSLOT-1:0]   pad_req,
    output logic [7:0]         pad_out,
    input  logic [NSLOT*8-1:0] pad_in,
    input  logic [NSLOT-1:0]   pad_ack,
    output logic [NSLOT-1:0]   card_req,
    output logic [7:0]         card_out,
    input  logic [NSLOT*8-1:0] card_in,
    input  logic [NSLOT-1:0]   card_ack
);
    import mt_pkg::*;

    localparam int SW = $clog2(NSLOT);
    localparam int FW = $clog2(FRAME);
    localparam logic [SW-1:0] LAST_SLOT = SW'(NSLOT - 1);
    localparam logic [FW-1:0] LAST_POS  = FW'(FRAME - 1);
    localparam logic [NSLOT-1:0] ALL_SLOTS = '1;

    mt_state_e       state;
    logic [SW-1:0]   slot;
    logic [FW-1:0]   pos;
    logic            armed;
    logic            bad_cmd;
    logic            slot_done;

    logic            dec_pad, dec_card;
    logic [SW-1:0]   dec_slot;
    logic [SW-1:0]   mux_sel;
    logic [7:0]      pad_rx, card_rx;
    logic            pad_rx_ack, card_rx_ack;
    logic            buf_we;
    logic [7:0]      buf_wd, buf_rd;
    logic [NSLOT-1:0] slot_oh, dec_oh;
    logic            frame_end, tap_end;

    mt_first_decode #(.NSLOT(NSLOT)) u_dec (
        .byte_in (host_in),
        .is_pad  (dec_pad),
        .is_card (dec_card),
        .slot    (dec_slot)
    );

    mt_slot_mux #(.NSLOT(NSLOT)) u_pad_mux (
        .rx_bus  (pad_in),
        .ack_bus (pad_ack),
        .sel     (mux_sel),
        .rx      (pad_rx),
        .ack     (pad_rx_ack)
    );

    mt_slot_mux #(.NSLOT(NSLOT)) u_card_mux (
        .rx_bus  (card_in),
        .ack_bus (card_ack),
        .sel     (mux_sel),
        .rx      (card_rx),
        .ack     (card_rx_ack)
    );

    mt_gather_buf #(.FRAME(FRAME)) u_buf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (buf_we),
        .idx   (pos),
        .wdata (buf_wd),
        .rdata (buf_rd)
    );

    // Slot selects and frame boundary flags
    always_comb begin
        slot_oh   = NSLOT'(1) << slot;
        dec_oh    = NSLOT'(1) << dec_slot;
        mux_sel   = (state == ST_IDLE) ? dec_slot : slot;
        frame_end = (pos == LAST_POS);
        tap_end   = frame_end && (slot == LAST_SLOT);
    end

    // Per-byte routing and host response
    always_comb begin
        pad_req  = '0;
        card_req = '0;
        pad_out  = host_in;
        card_out = host_in;
        host_out = IDLE_BYTE;
        host_ack = 1'b0;
        buf_we   = 1'b0;
        buf_wd   = IDLE_BYTE;
        if (host_valid) begin
            unique case (state)
                ST_IDLE: begin
                    if (dec_pad) begin
                        pad_out  = PAD_ACCESS;
                        pad_req  = armed ? ALL_SLOTS : dec_oh;
                        host_out = pad_rx;
                        host_ack = pad_rx_ack;
                    end else if (dec_card) begin
                        card_out = CARD_ACCESS;
                        card_req = dec_oh;
                        host_out = card_rx;
                        host_ack = card_rx_ack;
                    end
                end
                ST_MCARD: begin
                    card_req = slot_oh;
                    host_out = card_rx;
                    host_ack = card_rx_ack;
                end
                ST_CMD: begin
                    if (armed) begin
                        host_out = TAP_ID;
                        host_ack = 1'b1;
                    end else begin
                        pad_req  = slot_oh;
                        host_out = pad_rx;
                        host_ack = pad_rx_ack;
                    end
                end
                ST_REQ: begin
                    if (armed) begin
                        host_out = TAP_STATUS;
                        host_ack = !bad_cmd;
                    end else begin
                        pad_out  = 8'h00;
                        pad_req  = slot_oh;
                        host_out = pad_rx;
                        host_ack = pad_rx_ack;
                    end
                end
                ST_SINGLE: begin
                    pad_req  = slot_oh;
                    host_out = pad_rx;
                    host_ack = pad_rx_ack;
                end
                ST_GATHER: begin
                    host_out = buf_rd;
                    host_ack = !tap_end;
                    buf_we   = 1'b1;
                    if (!slot_done) begin
                        pad_req = slot_oh;
                        buf_wd  = pad_rx;
                    end
                end
                default: ;
            endcase
        end
    end

    // Sequence state, counters and the armed gather flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            slot      <= '0;
            pos       <= '0;
            armed     <= 1'b0;
            bad_cmd   <= 1'b0;
            slot_done <= 1'b0;
        end else if (seq_end) begin
            state     <= ST_IDLE;
            slot      <= '0;
            pos       <= '0;
            slot_done <= 1'b0;
        end else if (host_valid) begin
            unique case (state)
                ST_IDLE: begin
                    if (dec_pad && pad_rx_ack) begin
                        slot  <= dec_slot;
                        state <= ST_CMD;
                    end else if (dec_card && card_rx_ack) begin
                        slot  <= dec_slot;
                        state <= ST_MCARD;
                    end
                end
                ST_MCARD: if (!card_rx_ack) state <= ST_IDLE;
                ST_CMD: begin
                    if (armed) bad_cmd <= (host_in != GATHER_CMD);
                    state <= ST_REQ;
                end
                ST_REQ: begin
                    armed <= host_in[0];
                    if (armed) begin
                        slot      <= '0;
                        pos       <= '0;
                        slot_done <= 1'b0;
                        state     <= ST_GATHER;
                    end else begin
                        state <= ST_SINGLE;
                    end
                end
                ST_SINGLE: if (!pad_rx_ack) state <= ST_IDLE;
                ST_GATHER: begin
                    pos <= (pos == LAST_POS) ? '0 : pos + 1'b1;
                    if (frame_end) begin
                        slot_done <= 1'b0;
                        slot      <= (slot == LAST_SLOT) ? '0 : slot + 1'b1;
                        if (tap_end) state <= ST_IDLE;
                    end else if (!slot_done) begin
                        slot_done <= !pad_rx_ack;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/mt_route_chk.sv
// Property checker for mt_route, attached by bind. Assumes seq_end and
// host_valid are never high together.
module mt_route_chk #(
    parameter int NSLOT = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               host_valid,
    input logic [7:0]         host_in,
    input logic               seq_end,
    input logic [7:0]         host_out,
    input logic               host_ack,
    input logic [NSLOT-1:0]   pad_req,
    input logic [NSLOT-1:0]   card_req,
    input mt_pkg::mt_state_e  st
);
    import mt_pkg::*;

    logic known_code;
    always_comb known_code = (host_in[6:0] >= 7'd1) && (host_in[6:0] <= 7'(NSLOT));

    // R2
    bad_first_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_valid && st == ST_IDLE && !known_code) |-> (host_out == 8'hFF && !host_ack));

    // R2
    bad_first_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_valid && !seq_end && st == ST_IDLE && !known_code) |=> (st == ST_IDLE));

    // R3
    one_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(card_req) && !((|pad_req) && (|card_req)));

    // R1
    quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !host_valid |-> (pad_req == '0 && card_req == '0 && !host_ack));

    // R4
    card_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_valid && !seq_end && st == ST_MCARD && !host_ack) |=> (st == ST_IDLE));

    // R11
    gather_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_valid && !seq_end && st == ST_GATHER && !host_ack) |=> (st == ST_IDLE));

    // R12
    seq_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_end |=> (st == ST_IDLE));
endmodule

bind mt_route mt_route_chk #(.NSLOT(NSLOT)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_valid (host_valid),
    .host_in    (host_in),
    .seq_end    (seq_end),
    .host_out   (host_out),
    .host_ack   (host_ack),
    .pad_req    (pad_req),
    .card_req   (card_req),
    .st         (state)
);

// File: tb/mt_route_tb.sv
// Scoreboard bench for mt_route with counter-based endpoint models.
module mt_route_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_valid = 1'b0;
    logic [7:0]  host_in = 8'h00;
    logic        seq_end = 1'b0;
    logic [7:0]  host_out;
    logic        host_ack;
    logic [3:0]  pad_req, card_req;
    logic [7:0]  pad_out, card_out;
    logic [31:0] pad_in, card_in;
    logic [3:0]  pad_ack, card_ack;

    int checks = 0;
    int errors = 0;
    bit done_run = 1'b0;

    always #2 clk = ~clk;

    mt_route u_dut (
        .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_in(host_in),
        .seq_end(seq_end), .host_out(host_out), .host_ack(host_ack),
        .pad_req(pad_req), .pad_out(pad_out), .pad_in(pad_in), .pad_ack(pad_ack),
        .card_req(card_req), .card_out(card_out), .card_in(card_in), .card_ack(card_ack)
    );

    // Endpoint models: answer depends on slot and bytes seen this sequence
    logic [5:0] pcnt [4];
    logic [5:0] ccnt [4];
    int  plen [4] = '{5, 3, 12, 4};
    int  clen [4] = '{2, 2, 3, 2};
    bit  ppres [4] = '{1'b1, 1'b1, 1'b1, 1'b1};
    bit  cpres [4] = '{1'b1, 1'b1, 1'b1, 1'b1};

    function automatic logic [7:0] pmodel(int s, int c);
        return 8'((s << 5) | c);
    endfunction
    function automatic logic [7:0] cmodel(int s, int c);
        return 8'(8'h80 | (s << 4) | c);
    endfunction

    for (genvar s = 0; s < 4; s++) begin : g_ep
        always_comb begin
            pad_in[s*8 +: 8]  = ppres[s] ? pmodel(s, int'(pcnt[s])) : 8'hFF;
            pad_ack[s]        = ppres[s] && (int'(pcnt[s]) < plen[s]);
            card_in[s*8 +: 8] = cpres[s] ? cmodel(s, int'(ccnt[s])) : 8'hFF;
            card_ack[s]       = cpres[s] && (int'(ccnt[s]) < clen[s]);
        end
        always @(posedge clk) begin
            if (!rst_n || seq_end) begin
                pcnt[s] <= '0;
                ccnt[s] <= '0;
            end else begin
                if (pad_req[s])  pcnt[s] <= pcnt[s] + 1'b1;
                if (card_req[s]) ccnt[s] <= ccnt[s] + 1'b1;
            end
        end
    end

    typedef struct {
        logic [7:0] rsp;
        logic       ack;
        bit         ctx;
        logic [7:0] tx;
        bit         creq;
        logic [3:0] req;
        int         tag;
    } exp_t;
    exp_t q[$];

    task automatic fail_line(int tag, string what, int act, int exp);
        errors++;
        $display("FAIL R%0d %s: actual %0h expected %0h", tag, what, act, exp);
    endtask

    // Driver: present one host byte and queue what it must produce
    task automatic xfer(input logic [7:0] b, input logic [7:0] rsp, input logic ack,
                        input bit ctx, input logic [7:0] tx, input bit creq,
                        input logic [3:0] req, input int tag);
        exp_t e;
        @(negedge clk);
        seq_end    = 1'b0;
        host_valid = 1'b1;
        host_in    = b;
        e.rsp = rsp; e.ack = ack; e.ctx = ctx; e.tx = tx;
        e.creq = creq; e.req = req; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic xb(input logic [7:0] b, input logic [7:0] rsp, input logic ack, input int tag);
        xfer(b, rsp, ack, 1'b0, 8'h00, 1'b0, 4'h0, tag);
    endtask

    task automatic end_seq();
        @(negedge clk);
        host_valid = 1'b0;
        seq_end    = 1'b1;
        @(negedge clk);
        seq_end    = 1'b0;
    endtask

    // Monitor: compare each exchanged byte against the queue head
    always @(negedge clk) begin
        #1;
        if (host_valid && q.size() > 0) begin
            exp_t e;
            logic [7:0] txv;
            e = q.pop_front();
            checks++;
            if (host_out !== e.rsp) fail_line(e.tag, "response", host_out, e.rsp);
            else if (host_ack !== e.ack) fail_line(e.tag, "ack", host_ack, e.ack);
            else if (e.ctx) begin
                txv = (|card_req) ? card_out : pad_out;
                if (txv !== e.tx) fail_line(e.tag, "forwarded byte", txv, e.tx);
            end
            if (e.creq && pad_req !== e.req) fail_line(e.tag, "pad request", pad_req, e.req);
        end
    end

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done_run) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        logic [7:0] eb [8];
        int c [4];
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset outputs with no byte presented
        checks++;
        if (host_out !== 8'hFF || host_ack !== 1'b0 || pad_req !== 4'h0 || card_req !== 4'h0)
            fail_line(1, "reset outputs", {host_ack, host_out}, 9'h0FF);

        // R2: unknown first bytes
        xb(8'h55, 8'hFF, 1'b0, 2);
        xb(8'h00, 8'hFF, 1'b0, 2);
        xb(8'h85, 8'hFF, 1'b0, 2);
        xb(8'h05, 8'hFF, 1'b0, 2);
        end_seq();

        // R3, R5: single controller on slot 1
        xfer(8'h02, 8'h20, 1'b1, 1'b1, 8'h01, 1'b1, 4'b0010, 3);
        xfer(8'h42, 8'h21, 1'b1, 1'b1, 8'h42, 1'b0, 4'h0, 5);
        xfer(8'h00, 8'h22, 1'b1, 1'b1, 8'h00, 1'b0, 4'h0, 5);
        xb(8'h00, 8'h23, 1'b0, 5);
        xb(8'h33, 8'hFF, 1'b0, 5);
        end_seq();

        // R3, R4: memory card on slot 2
        xfer(8'h83, 8'hA0, 1'b1, 1'b1, 8'h81, 1'b0, 4'h0, 3);
        xfer(8'h52, 8'hA1, 1'b1, 1'b1, 8'h52, 1'b0, 4'h0, 4);
        xb(8'h00, 8'hA2, 1'b1, 4);
        xb(8'h00, 8'hA3, 1'b0, 4);
        xb(8'h77, 8'hFF, 1'b0, 4);
        end_seq();

        // R3: absent card leaves the block idle
        cpres[3] = 1'b0;
        xb(8'h84, 8'hFF, 1'b0, 3);
        xb(8'h82, 8'h90, 1'b1, 3);
        end_seq();
        cpres[3] = 1'b1;

        // R3: absent controller leaves the block idle
        ppres[3] = 1'b0;
        xb(8'h04, 8'hFF, 1'b0, 3);
        xb(8'h01, 8'h00, 1'b1, 3);
        end_seq();
        ppres[3] = 1'b1;

        // R12: sequence end mid-transfer
        xb(8'h03, 8'h40, 1'b1, 12);
        xb(8'h42, 8'h41, 1'b1, 12);
        end_seq();
        xb(8'h42, 8'hFF, 1'b0, 12);
        end_seq();

        // R6: arm gather via request bit 0, then end the sequence
        xb(8'h01, 8'h00, 1'b1, 6);
        xb(8'h42, 8'h01, 1'b1, 6);
        xfer(8'h01, 8'h02, 1'b1, 1'b1, 8'h00, 1'b0, 4'h0, 6);
        xb(8'h00, 8'h03, 1'b1, 6);
        end_seq();

        // R7, R8: armed selection broadcasts; tap id and status
        xfer(8'h01, 8'h00, 1'b1, 1'b1, 8'h01, 1'b1, 4'hF, 7);
        xfer(8'h42, 8'h80, 1'b1, 1'b0, 8'h00, 1'b1, 4'h0, 8);
        xb(8'h00, 8'h5A, 1'b1, 8);

        // R9, R10, R11: four frames of eight, first frame from reset fill (R1)
        for (int k = 0; k < 8; k++) eb[k] = 8'hFF;
        for (int s = 0; s < 4; s++) c[s] = 1;
        for (int s = 0; s < 4; s++) begin
            bit dn;
            dn = 1'b0;
            for (int k = 0; k < 8; k++) begin
                logic [7:0] r;
                logic a;
                int tg;
                r  = eb[k];
                a  = !(s == 3 && k == 7);
                tg = (s == 0) ? 1 : ((s == 3 && k == 7) ? 11 : 9);
                if (!dn) begin
                    eb[k] = pmodel(s, c[s]);
                    dn    = !(c[s] < plen[s]);
                    c[s]++;
                    xfer(8'(8'h10 + k), r, a, 1'b1, 8'(8'h10 + k), 1'b1, 4'(1 << s), tg);
                end else begin
                    eb[k] = 8'hFF;
                    xfer(8'(8'h10 + k), r, a, 1'b0, 8'h00, 1'b1, 4'h0, 10);
                end
            end
        end
        xb(8'h99, 8'hFF, 1'b0, 11);
        end_seq();

        // R6, R7: flag cleared by the last request, no broadcast now
        xfer(8'h01, 8'h00, 1'b1, 1'b0, 8'h00, 1'b1, 4'b0001, 7);
        xb(8'h42, 8'h01, 1'b1, 6);
        xb(8'h01, 8'h02, 1'b1, 6);
        end_seq();

        // R8: bad gather command is answered but the status is not acked
        xfer(8'h02, 8'h20, 1'b1, 1'b0, 8'h00, 1'b1, 4'hF, 8);
        xb(8'h43, 8'h80, 1'b1, 8);
        xb(8'h00, 8'h5A, 1'b0, 8);
        end_seq();

        repeat (3) @(negedge clk);
        if (q.size() != 0) begin
            checks++;
            fail_line(9, "unconsumed expectations", q.size(), 0);
        end
        done_run = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule